// File: doc/BRIEF.md
# Keyboard Controller Command Processor

This block is the host side of a PC-style keyboard controller. The host writes bytes through one interface, and a select line marks each byte for either the command port or the data port. Command bytes are decoded at once. Some of them act on the controller's own registers: the mode byte, the status byte and the output-port byte. Some return a one-byte reply. Some arm a pending destination that captures the next data-port byte.

When no destination is armed, a data-port byte goes to the keyboard on a forward strobe. An armed destination can send the byte to any of these:
- the mouse,
- the mode register,
- the output port,
- the reply path, tagged keyboard or auxiliary.

The block drives the A20 gate from output-port bit 1. It lowers an active-low CPU reset line for a fixed number of cycles when a reset is requested.

The device models, their queues and the serial line sit outside this block. They consume the reply and forward strobes.

Top module: `kbc_cmd_proc`

## Requirements
- R1: A command-port write of 0x60, 0xD1, 0xD2, 0xD3 or 0xD4 arms a pending destination. It produces no reply and no forward strobe, and the next data-port byte is captured by that destination. A command that arms nothing leaves any armed destination in place.
- R2: A data-port write is routed by the armed destination, and the destination then returns to keyboard.
  - With nothing armed, the byte appears on `fwd_data` with `fwd_kbd_valid`.
  - After 0xD4, it appears with `fwd_mouse_valid`.
  - A forward strobe lasts one cycle, in the cycle after the write.
- R3: Replies are strobed on `rsp_valid` for one cycle, in the cycle after the write:
  - 0x20 replies with the mode byte.
  - 0xD0 replies with the output-port byte.
  - 0xC0 replies with 0x80.
  - 0xAA replies with 0x55.
  - 0xA9 and 0xAB reply with 0x00.
  - A data byte after 0xD2 is replied with `rsp_aux`=0, and after 0xD3 with `rsp_aux`=1. All other replies carry `rsp_aux`=0.
- R4: 0xA7 sets mode bit 5 and 0xA8 clears it. 0xAD sets mode bit 4 and 0xAE clears it. A data byte after 0x60 replaces the whole mode byte. Nothing else changes the mode byte.
- R5: Status bit 3 is set by every command-port write and cleared by every data-port write. 0xAA sets status bit 2.
- R6: 0xDF sets output-port bit 1 and 0xDD clears it. A data byte after 0xD1 replaces the whole output-port byte. `a20_out` always equals output-port bit 1.
- R7: A command whose upper nibble is 0xF and whose bit 0 is 0 requests a CPU reset. So does a data byte after 0xD1 whose bit 0 is 0. `cpu_rst_n` goes low in the cycle after the request and stays low for PULSE_CYC cycles. A request made while it is low does not lengthen the pulse.
- R8: A command with upper nibble 0xF and bit 0 set changes no state and raises no strobe. Any command value outside the decoded set changes no state and raises `bad_cmd` for one cycle, in the cycle after the write.
- R9: After reset the mode byte is 0x03, the status byte is 0x18 and the output port is 0xCF. `a20_out` and `cpu_rst_n` are high and every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_is_cmd | input | 1 | 1 selects the command port, 0 the data port |
| wr_data | input | 8 | Written byte |
| rsp_valid | output | 1 | Reply byte strobe |
| rsp_aux | output | 1 | Reply belongs to the auxiliary channel |
| rsp_data | output | 8 | Reply byte |
| fwd_kbd_valid | output | 1 | Forward byte to the keyboard |
| fwd_mouse_valid | output | 1 | Forward byte to the mouse |
| fwd_data | output | 8 | Forwarded byte |
| a20_out | output | 1 | A20 gate level |
| cpu_rst_n | output | 1 | Active-low CPU reset pulse |
| bad_cmd | output | 1 | Unrecognised command strobe |
| mode_o | output | 8 | Mode byte |
| status_o | output | 8 | Status byte |
| outport_o | output | 8 | Output-port byte |

## Verification
The stimulus covers several patterns:
- Each reply command on its own, which checks every reply source.
- Each of the five arming commands followed by a data byte, which shows that routing depends on the armed destination and not on the byte value.
- A bare data byte, which confirms the keyboard default.
- A non-arming command placed between an arming command and its data byte, which separates "cleared by any command" from "cleared only by data".
- Reset requests before and during a pulse, together with odd 0xFx values and stray codes. These show that the pulse length is fixed and that a no-op differs from an error.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  localparam int BYTE_W = 8;

  // command codes
  localparam logic [7:0] OP_RD_MODE   = 8'h20;
  localparam logic [7:0] OP_WR_MODE   = 8'h60;
  localparam logic [7:0] OP_AUX_OFF   = 8'hA7;
  localparam logic [7:0] OP_AUX_ON    = 8'hA8;
  localparam logic [7:0] OP_AUX_TEST  = 8'hA9;
  localparam logic [7:0] OP_SELF_TEST = 8'hAA;
  localparam logic [7:0] OP_KBD_TEST  = 8'hAB;
  localparam logic [7:0] OP_KBD_OFF   = 8'hAD;
  localparam logic [7:0] OP_KBD_ON    = 8'hAE;
  localparam logic [7:0] OP_RD_INPUT  = 8'hC0;
  localparam logic [7:0] OP_RD_OUTP   = 8'hD0;
  localparam logic [7:0] OP_WR_OUTP   = 8'hD1;
  localparam logic [7:0] OP_WR_KOBUF  = 8'hD2;
  localparam logic [7:0] OP_WR_AOBUF  = 8'hD3;
  localparam logic [7:0] OP_TO_MOUSE  = 8'hD4;
  localparam logic [7:0] OP_GATE_LOW  = 8'hDD;
  localparam logic [7:0] OP_GATE_HIGH = 8'hDF;

  // field positions
  localparam int MODE_AUX_OFF_BIT = 5;
  localparam int MODE_KBD_OFF_BIT = 4;
  localparam int STAT_CMDLAST_BIT = 3;
  localparam int STAT_SELFOK_BIT  = 2;
  localparam int OUTP_A20_BIT     = 1;
  localparam int OUTP_RUN_BIT     = 0;

  // reset values
  localparam logic [7:0] MODE_RST = 8'h03;
  localparam logic [7:0] STAT_RST = 8'h18;
  localparam logic [7:0] OUTP_RST = 8'hCF;

  // constant replies
  localparam logic [7:0] RPL_INPUT = 8'h80;
  localparam logic [7:0] RPL_SELF  = 8'h55;
  localparam logic [7:0] RPL_PASS  = 8'h00;

  typedef enum logic [2:0] {
    DST_KBD, DST_MODE, DST_OUTP, DST_KOBUF, DST_AOBUF, DST_MOUSE
  } dest_e;

  typedef enum logic [1:0] {SRC_CONST, SRC_MODE, SRC_OUTP} rsrc_e;

  typedef struct packed {
    logic        arm;
    dest_e       arm_dest;
    logic        reply;
    rsrc_e       reply_src;
    logic [7:0]  reply_val;
    logic        self_ok;
    logic        aux_off;
    logic        aux_on;
    logic        kbd_off;
    logic        kbd_on;
    logic        gate_hi;
    logic        gate_lo;
    logic        rst_req;
    logic        unknown;
  } cmd_dec_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] code,
  output cmd_dec_t          dec
);

  always_comb begin
    dec.arm       = 1'b0;
    dec.arm_dest  = DST_KBD;
    dec.reply     = 1'b0;
    dec.reply_src = SRC_CONST;
    dec.reply_val = 8'h00;
    dec.self_ok   = 1'b0;
    dec.aux_off   = 1'b0;
    dec.aux_on    = 1'b0;
    dec.kbd_off   = 1'b0;
    dec.kbd_on    = 1'b0;
    dec.gate_hi   = 1'b0;
    dec.gate_lo   = 1'b0;
    dec.rst_req   = 1'b0;
    dec.unknown   = 1'b0;
    if (code[7:4] == 4'hF) begin
      // pulse family: even value pulses reset, odd value does nothing
      dec.rst_req = ~code[0];
    end else begin
      case (code)
        OP_RD_MODE:   begin dec.reply = 1'b1; dec.reply_src = SRC_MODE; end
        OP_RD_OUTP:   begin dec.reply = 1'b1; dec.reply_src = SRC_OUTP; end
        OP_RD_INPUT:  begin dec.reply = 1'b1; dec.reply_val = RPL_INPUT; end
        OP_SELF_TEST: begin dec.reply = 1'b1; dec.reply_val = RPL_SELF; dec.self_ok = 1'b1; end
        OP_AUX_TEST,
        OP_KBD_TEST:  begin dec.reply = 1'b1; dec.reply_val = RPL_PASS; end
        OP_WR_MODE:   begin dec.arm = 1'b1; dec.arm_dest = DST_MODE; end
        OP_WR_OUTP:   begin dec.arm = 1'b1; dec.arm_dest = DST_OUTP; end
        OP_WR_KOBUF:  begin dec.arm = 1'b1; dec.arm_dest = DST_KOBUF; end
        OP_WR_AOBUF:  begin dec.arm = 1'b1; dec.arm_dest = DST_AOBUF; end
        OP_TO_MOUSE:  begin dec.arm = 1'b1; dec.arm_dest = DST_MOUSE; end
        OP_AUX_OFF:   dec.aux_off = 1'b1;
        OP_AUX_ON:    dec.aux_on  = 1'b1;
        OP_KBD_OFF:   dec.kbd_off = 1'b1;
        OP_KBD_ON:    dec.kbd_on  = 1'b1;
        OP_GATE_HIGH: dec.gate_hi = 1'b1;
        OP_GATE_LOW:  dec.gate_lo = 1'b1;
        default:      dec.unknown = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/kbc_ctrl_regs.sv
module kbc_ctrl_regs
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  cmd_dec_t          dec,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] status_q,
  output logic [BYTE_W-1:0] outport_q,
  output dest_e             pend_q,
  output logic              rst_req
);

  logic [BYTE_W-1:0] mode_d, status_d, outport_d;
  dest_e             pend_d;
  logic              upd_en;

  assign upd_en = cmd_wr | dat_wr;

  always_comb begin
    mode_d    = mode_q;
    status_d  = status_q;
    outport_d = outport_q;
    pend_d    = pend_q;
    if (cmd_wr) begin
      status_d[STAT_CMDLAST_BIT] = 1'b1;
      if (dec.self_ok) status_d[STAT_SELFOK_BIT]  = 1'b1;
      if (dec.aux_off) mode_d[MODE_AUX_OFF_BIT]   = 1'b1;
      if (dec.aux_on)  mode_d[MODE_AUX_OFF_BIT]   = 1'b0;
      if (dec.kbd_off) mode_d[MODE_KBD_OFF_BIT]   = 1'b1;
      if (dec.kbd_on)  mode_d[MODE_KBD_OFF_BIT]   = 1'b0;
      if (dec.gate_hi) outport_d[OUTP_A20_BIT]    = 1'b1;
      if (dec.gate_lo) outport_d[OUTP_A20_BIT]    = 1'b0;
      if (dec.arm)     pend_d = dec.arm_dest;
    end
    if (dat_wr) begin
      status_d[STAT_CMDLAST_BIT] = 1'b0;
      if (pend_q == DST_MODE) mode_d    = wr_data;
      if (pend_q == DST_OUTP) outport_d = wr_data;
      pend_d = DST_KBD;
    end
  end

  assign rst_req = (cmd_wr & dec.rst_req) |
                   (dat_wr & (pend_q == DST_OUTP) & ~wr_data[OUTP_RUN_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_RST;
      status_q  <= STAT_RST;
      outport_q <= OUTP_RST;
      pend_q    <= DST_KBD;
    end else if (upd_en) begin
      mode_q    <= mode_d;
      status_q  <= status_d;
      outport_q <= outport_d;
      pend_q    <= pend_d;
    end
  end

endmodule

// File: rtl/kbc_egress.sv
module kbc_egress
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  cmd_dec_t          dec,
  input  dest_e             pend_q,
  input  logic [BYTE_W-1:0] mode_q,
  input  logic [BYTE_W-1:0] outport_q,
  output logic              rsp_valid,
  output logic              rsp_aux,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              fwd_kbd_valid,
  output logic              fwd_mouse_valid,
  output logic [BYTE_W-1:0] fwd_data,
  output logic              bad_cmd
);

  logic              rv_d, ra_d, fk_d, fm_d, bad_d;
  logic [BYTE_W-1:0] rd_d;

  always_comb begin
    rv_d  = 1'b0;
    ra_d  = 1'b0;
    rd_d  = rsp_data;
    fk_d  = 1'b0;
    fm_d  = 1'b0;
    bad_d = cmd_wr & dec.unknown;
    if (cmd_wr && dec.reply) begin
      rv_d = 1'b1;
      case (dec.reply_src)
        SRC_MODE: rd_d = mode_q;
        SRC_OUTP: rd_d = outport_q;
        default:  rd_d = dec.reply_val;
      endcase
    end
    if (dat_wr) begin
      case (pend_q)
        DST_KBD:   fk_d = 1'b1;
        DST_MOUSE: fm_d = 1'b1;
        DST_KOBUF: begin rv_d = 1'b1; rd_d = wr_data; end
        DST_AOBUF: begin rv_d = 1'b1; ra_d = 1'b1; rd_d = wr_data; end
        default: ;
      endcase
    end
  end

  // strobes every cycle, payloads only when written
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_aux         <= 1'b0;
      fwd_kbd_valid   <= 1'b0;
      fwd_mouse_valid <= 1'b0;
      bad_cmd         <= 1'b0;
    end else begin
      rsp_valid       <= rv_d;
      rsp_aux         <= ra_d;
      fwd_kbd_valid   <= fk_d;
      fwd_mouse_valid <= fm_d;
      bad_cmd         <= bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
      fwd_data <= '0;
    end else begin
      if (rv_d)        rsp_data <= rd_d;
      if (fk_d | fm_d) fwd_data <= wr_data;
    end
  end

endmodule

// File: rtl/kbc_reset_pulse.sv
module kbc_reset_pulse #(
  parameter int PULSE_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic cpu_rst_n
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (busy)     cnt_d = cnt_q - 1'b1;
    else if (req) cnt_d = CNT_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (busy || req)  cnt_q <= cnt_d;
  end

  assign cpu_rst_n = ~busy;

endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
  import kbc_pkg::*;
#(
  parameter int PULSE_CYC = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_is_cmd,
  input  logic [7:0] wr_data,
  output logic       rsp_valid,
  output logic       rsp_aux,
  output logic [7:0] rsp_data,
  output logic       fwd_kbd_valid,
  output logic       fwd_mouse_valid,
  output logic [7:0] fwd_data,
  output logic       a20_out,
  output logic       cpu_rst_n,
  output logic       bad_cmd,
  output logic [7:0] mode_o,
  output logic [7:0] status_o,
  output logic [7:0] outport_o
);

  cmd_dec_t dec;
  dest_e    pend_q;
  logic     cmd_wr, dat_wr, rst_req;

  assign cmd_wr = wr_en &  wr_is_cmd;
  assign dat_wr = wr_en & ~wr_is_cmd;

  kbc_cmd_decode u_dec (.code(wr_data), .dec(dec));

  kbc_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr),
    .wr_data(wr_data), .dec(dec), .mode_q(mode_o), .status_q(status_o),
    .outport_q(outport_o), .pend_q(pend_q), .rst_req(rst_req)
  );

  kbc_egress u_egr (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr),
    .wr_data(wr_data), .dec(dec), .pend_q(pend_q), .mode_q(mode_o),
    .outport_q(outport_o), .rsp_valid(rsp_valid), .rsp_aux(rsp_aux),
    .rsp_data(rsp_data), .fwd_kbd_valid(fwd_kbd_valid),
    .fwd_mouse_valid(fwd_mouse_valid), .fwd_data(fwd_data), .bad_cmd(bad_cmd)
  );

  kbc_reset_pulse #(.PULSE_CYC(PULSE_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .req(rst_req), .cpu_rst_n(cpu_rst_n)
  );

  assign a20_out = outport_o[OUTP_A20_BIT];

endmodule

// File: rtl/kbc_cmd_proc_chk.sv
module kbc_cmd_proc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_is_cmd,
  input logic       rsp_valid,
  input logic       fwd_kbd_valid,
  input logic       fwd_mouse_valid,
  input logic       cpu_rst_n,
  input logic       bad_cmd,
  input logic [7:0] mode_o,
  input logic [7:0] status_o
);

  AST_ONE_EGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, fwd_kbd_valid, fwd_mouse_valid})); // R2
  AST_FWD_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_kbd_valid || fwd_mouse_valid) |-> $past(wr_en && !wr_is_cmd)); // R2
  AST_RSP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(wr_en)); // R3
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_o)); // R4
  AST_CMDLAST_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (status_o[3] == $past(wr_is_cmd))); // R5
  AST_RST_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst_n) |-> $past(wr_en)); // R7
  AST_BAD_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |-> $past(wr_en && wr_is_cmd)); // R8

endmodule

bind kbc_cmd_proc kbc_cmd_proc_chk u_chk (.*);

// File: tb/kbc_cmd_proc_test.sv
`timescale 1ns/1ps
module kbc_cmd_proc_test;

  localparam int PULSE = 300;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_is_cmd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rsp_valid, rsp_aux, fwd_kbd_valid, fwd_mouse_valid;
  logic a20_out, cpu_rst_n, bad_cmd;
  logic [7:0] rsp_data, fwd_data, mode_o, status_o, outport_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_mode, m_stat, m_outp, m_pend, m_rleft;
  int e_rv, e_ra, e_rd, e_fk, e_fm, e_fd, e_bad;

  always #(TCK/2) clk = ~clk;

  kbc_cmd_proc #(.PULSE_CYC(PULSE)) uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_known(int c);
    case (c)
      'h20,'h60,'hA7,'hA8,'hA9,'hAA,'hAB,'hAD,'hAE,'hC0,
      'hD0,'hD1,'hD2,'hD3,'hD4,'hDD,'hDF: return 1;
      default: return (c >= 'hF0);
    endcase
  endfunction

  task automatic compare_all();
    chk("R3 rsp_valid", rsp_valid, e_rv);
    if (e_rv) begin
      chk("R3 rsp_data", rsp_data, e_rd);
      chk("R3 rsp_aux", rsp_aux, e_ra);
    end
    chk("R2 fwd_kbd_valid", fwd_kbd_valid, e_fk);
    chk("R2 fwd_mouse_valid", fwd_mouse_valid, e_fm);
    if (e_fk || e_fm) chk("R2 fwd_data", fwd_data, e_fd);
    chk("R4 mode", mode_o, m_mode);
    chk("R5 status", status_o, m_stat);
    chk("R6 outport", outport_o, m_outp);
    chk("R6 a20", a20_out, (m_outp >> 1) & 1);
    chk("R7 cpu_rst_n", cpu_rst_n, m_rleft == 0);
    chk("R8 bad_cmd", bad_cmd, e_bad);
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(bit we, bit cmd, int d);
    int req, prev;
    wr_en = we; wr_is_cmd = cmd; wr_data = d[7:0];
    @(posedge clk);
    e_rv = 0; e_ra = 0; e_fk = 0; e_fm = 0; e_bad = 0; req = 0;
    if (we && cmd) begin
      m_stat |= 'h08;
      if (d >= 'hF0) req = ((d & 1) == 0);
      else if (!is_known(d)) e_bad = 1;
      else case (d)
        'h20: begin e_rv = 1; e_rd = m_mode; end
        'hD0: begin e_rv = 1; e_rd = m_outp; end
        'hC0: begin e_rv = 1; e_rd = 'h80; end
        'hAA: begin e_rv = 1; e_rd = 'h55; m_stat |= 'h04; end
        'hA9, 'hAB: begin e_rv = 1; e_rd = 0; end
        'hA7: m_mode |= 'h20;
        'hA8: m_mode &= ~'h20;
        'hAD: m_mode |= 'h10;
        'hAE: m_mode &= ~'h10;
        'hDF: m_outp |= 'h02;
        'hDD: m_outp &= ~'h02;
        default: m_pend = d;   // the five arming commands
      endcase
    end else if (we) begin
      m_stat &= ~'h08;
      case (m_pend)
        'h60: m_mode = d;
        'hD1: begin m_outp = d; req = ((d & 1) == 0); end
        'hD2: begin e_rv = 1; e_rd = d; end
        'hD3: begin e_rv = 1; e_ra = 1; e_rd = d; end
        'hD4: begin e_fm = 1; e_fd = d; end
        default: begin e_fk = 1; e_fd = d; end
      endcase
      m_pend = 0;
    end
    prev = m_rleft;
    if (m_rleft > 0) m_rleft--;
    else if (req) m_rleft = PULSE;
    @(negedge clk);
    wr_en = 0;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_mode = 'h03; m_stat = 'h18; m_outp = 'hCF; m_pend = 0; m_rleft = 0;
    e_rv = 0; e_ra = 0; e_rd = 0; e_fk = 0; e_fm = 0; e_fd = 0; e_bad = 0;
    repeat (3) @(negedge clk);
    compare_all();                 // R9 reset values
    rst_n = 1'b1;
    idle(2);                       // R9 held after release

    // R3 reply sources
    cyc(1, 1, 'h20); cyc(1, 1, 'hD0); cyc(1, 1, 'hC0);
    cyc(1, 1, 'hAA); cyc(1, 1, 'hA9); cyc(1, 1, 'hAB);
    // R2 default keyboard forward, R5 cmd-last cleared
    cyc(1, 0, 'h5A); idle(1);
    // R1 arm mouse, idle gap produces nothing, then R2 mouse forward
    cyc(1, 1, 'hD4); idle(2); cyc(1, 0, 'hF4);
    // R3 keyboard / auxiliary echo
    cyc(1, 1, 'hD2); cyc(1, 0, 'h11);
    cyc(1, 1, 'hD3); cyc(1, 0, 'h22);
    // R1 non-arming command between arm and data keeps the destination
    cyc(1, 1, 'hD2); cyc(1, 1, 'h20); cyc(1, 0, 'h33);
    // R4 mode load and bit commands
    cyc(1, 1, 'h60); cyc(1, 0, 'h47); cyc(1, 1, 'h20);
    cyc(1, 1, 'hA7); cyc(1, 1, 'hA8); cyc(1, 1, 'hAD); cyc(1, 1, 'hAE);
    cyc(1, 0, 'h01);               // back to keyboard default
    // R6 gate commands
    cyc(1, 1, 'hDD); cyc(1, 1, 'hD0); cyc(1, 1, 'hDF); cyc(1, 1, 'hD0);
    cyc(1, 1, 'hD1); cyc(1, 0, 'hCD); idle(1);   // bit1 low, bit0 high: no reset
    // R8 odd pulse no-op and unknown codes
    cyc(1, 1, 'hF1); cyc(1, 1, 'hFF); cyc(1, 1, 'h12); cyc(1, 1, 'hB5); idle(1);
    // R7 reset through output port write, then a request mid-pulse
    cyc(1, 1, 'hD1); cyc(1, 0, 'hCE);
    idle(100);
    cyc(1, 1, 'hFE);
    idle(PULSE);
    // R7 reset through pulse command after the line recovered
    cyc(1, 1, 'hD1); cyc(1, 0, 'hCF);
    cyc(1, 1, 'hF0);
    idle(PULSE + 5);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule